// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Sequencer

This block connects an internal request stream to an external asynchronous static memory bus shared by up to four devices: SRAM, PSRAM or NOR. Each accepted request is a single read or write to one bank. The block walks through a fixed order of timed phases and drives the bank's chip select, the output and write strobes, the byte lanes, the address, and the data lines (or the multiplexed address/data lines). Only one external access is in progress at any time.

Every phase length is a count of internal clock cycles from 0 to 15. The phases are byte-lane lead, address setup, address hold, data setup, data hold and turnaround. Writes can use a second timing set of their own. A wait input stretches data setup when it is enabled, and its polarity is programmable. The bus can be 8 or 16 bits wide.

The request side is valid/ready. A request must hold `req_valid` and its fields stable until it is accepted, which happens on a clock edge where `req_ready` is high. `req_ready` stays low from acceptance until the turnaround has ended. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse, and the consumer must take `rsp_rdata` in that cycle.

Top module: `asm_mem_seq`

## Requirements
- R1: After reset, `req_ready`=1, `rsp_valid`=0, all `mem_cs_n` bits are 1, `mem_oe_n`=1, `mem_we_n`=1, `mem_adv_n`=1 and `mem_dq_oe`=0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the following cycle until the access and its turnaround end, so a second request cannot start an access.
- R3: Counting the cycles after the accepting edge, `rsp_valid` is high for exactly one cycle, cycle N. N = lead + aset + ahld_eff + max(dset,1) + W + dhld, where W is the number of data-setup cycles with an honoured wait. This is the last cycle of data hold, or the last cycle of data setup when dhld=0.
- R4: `req_ready` rises again turn+1 cycles after the `rsp_valid` cycle.
- R5: The byte lanes of the request (`mem_bl_n[i]` low for lane i) go active exactly `cfg_blead` cycles before the chip select goes low.
- R6: Only `mem_cs_n[req_bank]` goes low during the access, and at most one chip select is low at any time.
- R7: The address hold phase is used only when `cfg_mux`=1 and `cfg_dev` is 1 (PSRAM) or 2 (NOR); code 0 is SRAM and code 3 is treated like SRAM. In multiplexed mode, `mem_adv_n` is low for the aset+ahld address cycles, and during those cycles `mem_dq_out` carries the address bits [15:0] with `mem_dq_oe`=1.
- R8: When `cfg_wr_sep`=1, writes use the `cfg_wr_*` timing set and reads keep the `cfg_rd_*` set.
- R9: With `cfg_bus8`=1, `mem_dq_out[15:8]` and `rsp_rdata[15:8]` are 0 and `mem_bl_n[1]` stays 1.
- R10: The wait is seen as asserted when `mem_wait` equals `cfg_wait_pol` (0 = active low). Each data-setup cycle with an asserted, enabled wait adds one cycle to data setup.
- R11: With `cfg_wait_en`=0, `mem_wait` has no effect on the access length or on the captured read data.
- R12: Read data is taken from `mem_dq_in` on the last data-setup cycle and is presented on `rsp_rdata` with `rsp_valid`. `mem_oe_n` and `mem_we_n` are never low together. While `mem_we_n` is low, `mem_dq_out` carries the write data with `mem_dq_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dev | input | 2 | Device kind: 0 SRAM, 1 PSRAM, 2 NOR |
| cfg_mux | input | 1 | Request multiplexed address/data |
| cfg_bus8 | input | 1 | 8-bit bus when 1, 16-bit when 0 |
| cfg_wait_en | input | 1 | Honour the wait input |
| cfg_wait_pol | input | 1 | Wait asserted level |
| cfg_blead | input | 4 | Byte-lane lead cycles |
| cfg_rd_aset | input | 4 | Address setup (read / shared set) |
| cfg_rd_ahld | input | 4 | Address hold (read / shared set) |
| cfg_rd_dset | input | 4 | Data setup (read / shared set) |
| cfg_rd_dhld | input | 4 | Data hold (read / shared set) |
| cfg_rd_turn | input | 4 | Turnaround (read / shared set) |
| cfg_wr_sep | input | 1 | Use write timing set for writes |
| cfg_wr_aset | input | 4 | Address setup, write set |
| cfg_wr_ahld | input | 4 | Address hold, write set |
| cfg_wr_dset | input | 4 | Data setup, write set |
| cfg_wr_dhld | input | 4 | Data hold, write set |
| cfg_wr_turn | input | 4 | Turnaround, write set |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | 2 | Bank number |
| req_addr | input | 24 | Address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane enables |
| rsp_valid | output | 1 | Access complete pulse |
| rsp_rdata | output | 16 | Read data |
| mem_cs_n | output | 4 | Chip selects, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bl_n | output | 2 | Byte lanes, active low |
| mem_addr | output | 24 | Address lines |
| mem_dq_out | output | 16 | Data / multiplexed address out |
| mem_dq_oe | output | 1 | Data line drive enable |
| mem_dq_in | input | 16 | Data lines in |
| mem_wait | input | 1 | Wait from the device |

## Verification
Two events can fall in the same cycle: the data-setup counter reaching its final cycle, and the wait input becoming asserted. The access must then neither end early nor capture data on a cycle where the wait is still raised. The bench's memory model raises wait on the first strobe cycle for a chosen number of cycles and drives a poison value on the data lines for as long as wait is up, with data setup set as short as one cycle. The expected access length and read value are computed for the enabled case, which stretches setup and captures clean data. They are also computed for the disabled case, which ignores the wait and may capture the poison value, and the observed `rsp_valid` cycle and `rsp_rdata` are compared with both predictions.

// File: rtl/asm_pkg.sv
package asm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_BLEAD = 3'd1,
    PH_ASET  = 3'd2,
    PH_AHLD  = 3'd3,
    PH_DSET  = 3'd4,
    PH_DHLD  = 3'd5,
    PH_TURN  = 3'd6
  } phase_e;

  localparam logic [1:0] DEV_SRAM  = 2'd0;
  localparam logic [1:0] DEV_PSRAM = 2'd1;
  localparam logic [1:0] DEV_NOR   = 2'd2;
endpackage

// File: rtl/asm_timing_sel.sv
module asm_timing_sel #(
  parameter int TW = 4
) (
  input  logic [1:0]    dev,
  input  logic          mux_req,
  input  logic          wr_sep,
  input  logic          is_write,
  input  logic [TW-1:0] rd_aset,
  input  logic [TW-1:0] rd_ahld,
  input  logic [TW-1:0] rd_dset,
  input  logic [TW-1:0] rd_dhld,
  input  logic [TW-1:0] rd_turn,
  input  logic [TW-1:0] wr_aset,
  input  logic [TW-1:0] wr_ahld,
  input  logic [TW-1:0] wr_dset,
  input  logic [TW-1:0] wr_dhld,
  input  logic [TW-1:0] wr_turn,
  output logic          mux_eff,
  output logic [TW-1:0] eff_aset,
  output logic [TW-1:0] eff_ahld,
  output logic [TW-1:0] eff_dset,
  output logic [TW-1:0] eff_dhld,
  output logic [TW-1:0] eff_turn
);
  import asm_pkg::*;

  logic          use_wr;
  logic [TW-1:0] raw_ahld, raw_dset;

  // multiplexing only legal for devices that latch an address from the data lines
  assign mux_eff = mux_req && (dev == DEV_PSRAM || dev == DEV_NOR);
  assign use_wr  = wr_sep && is_write;

  always_comb begin
    if (use_wr) begin
      eff_aset = wr_aset;
      raw_ahld = wr_ahld;
      raw_dset = wr_dset;
      eff_dhld = wr_dhld;
      eff_turn = wr_turn;
    end else begin
      eff_aset = rd_aset;
      raw_ahld = rd_ahld;
      raw_dset = rd_dset;
      eff_dhld = rd_dhld;
      eff_turn = rd_turn;
    end
  end

  assign eff_ahld = mux_eff ? raw_ahld : '0;
  assign eff_dset = (raw_dset == '0) ? TW'(1) : raw_dset;
endmodule

// File: rtl/asm_phase_ctrl.sv
module asm_phase_ctrl
  import asm_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wait_hold,
  input  logic [TW-1:0] t_blead,
  input  logic [TW-1:0] t_aset,
  input  logic [TW-1:0] t_ahld,
  input  logic [TW-1:0] t_dset,
  input  logic [TW-1:0] t_dhld,
  input  logic [TW-1:0] t_turn,
  output phase_e        phase,
  output logic          dset_end,
  output logic          done
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] nlen;
  logic [TW-1:0] nload;
  logic [2:0]    from;
  phase_e        nxt;
  logic          stalled;
  logic          phase_end;

  // first phase at or after 'f' whose length is non-zero; data setup is never empty
  function automatic phase_e pick(input logic [2:0] f);
    phase_e r;
    r = PH_IDLE;
    if (f <= 3'(PH_TURN) && t_turn != '0)  r = PH_TURN;
    if (f <= 3'(PH_DHLD) && t_dhld != '0)  r = PH_DHLD;
    if (f <= 3'(PH_DSET))                  r = PH_DSET;
    if (f <= 3'(PH_AHLD) && t_ahld != '0)  r = PH_AHLD;
    if (f <= 3'(PH_ASET) && t_aset != '0)  r = PH_ASET;
    if (f <= 3'(PH_BLEAD) && t_blead != '0) r = PH_BLEAD;
    return r;
  endfunction

  function automatic logic [TW-1:0] plen(input phase_e p);
    case (p)
      PH_BLEAD: return t_blead;
      PH_ASET:  return t_aset;
      PH_AHLD:  return t_ahld;
      PH_DSET:  return t_dset;
      PH_DHLD:  return t_dhld;
      PH_TURN:  return t_turn;
      default:  return '0;
    endcase
  endfunction

  assign stalled   = (phase == PH_DSET) && wait_hold;
  assign phase_end = (phase != PH_IDLE) && (cnt == '0) && !stalled;
  assign from      = start ? 3'(PH_BLEAD) : 3'(3'(phase) + 3'd1);

  always_comb begin
    nxt   = pick(from);
    nlen  = plen(nxt);
    nload = (nlen == '0) ? '0 : nlen - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (start || phase_end) begin
      phase <= nxt;
      cnt   <= nload;
    end else if (phase != PH_IDLE && !stalled) begin
      cnt <= cnt - TW'(1);
    end
  end

  assign dset_end = phase_end && (phase == PH_DSET);
  assign done     = phase_end &&
                    ((phase == PH_DHLD) || (phase == PH_DSET && t_dhld == '0));
endmodule

// File: rtl/asm_pin_drv.sv
module asm_pin_drv
  import asm_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 24,
  parameter int DW    = 16,
  localparam int BW   = $clog2(NBANK),
  localparam int NL   = DW / 8
) (
  input  phase_e          phase,
  input  logic            write_q,
  input  logic [BW-1:0]   bank_q,
  input  logic [AW-1:0]   addr_q,
  input  logic [DW-1:0]   wdata_q,
  input  logic [NL-1:0]   be_q,
  input  logic            mux_eff,
  input  logic [DW-1:0]   lane_mask,
  input  logic            bus8,
  output logic [NBANK-1:0] cs_n,
  output logic            adv_n,
  output logic            oe_n,
  output logic            we_n,
  output logic [NL-1:0]   bl_n,
  output logic [AW-1:0]   addr,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe
);
  logic in_cs, in_lane, in_addr, in_data;

  assign in_cs   = (phase == PH_ASET) || (phase == PH_AHLD) ||
                   (phase == PH_DSET) || (phase == PH_DHLD);
  assign in_lane = in_cs || (phase == PH_BLEAD);
  assign in_addr = mux_eff && ((phase == PH_ASET) || (phase == PH_AHLD));
  assign in_data = write_q && ((phase == PH_DSET) || (phase == PH_DHLD));

  for (genvar b = 0; b < NBANK; b++) begin : g_cs
    assign cs_n[b] = !(in_cs && bank_q == BW'(b));
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    if (l == 0) begin : g_low
      assign bl_n[l] = !(in_lane && be_q[l]);
    end else begin : g_high
      assign bl_n[l] = !(in_lane && be_q[l] && !bus8);
    end
  end

  assign adv_n  = !in_addr;
  assign oe_n   = !((phase == PH_DSET) && !write_q);
  assign we_n   = !((phase == PH_DSET) && write_q);
  assign addr   = addr_q;
  assign dq_oe  = in_addr || in_data;
  assign dq_out = (in_addr ? addr_q[DW-1:0] : wdata_q) & lane_mask;
endmodule

// File: rtl/asm_mem_seq.sv
module asm_mem_seq
  import asm_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int TW    = 4,
  localparam int BW   = $clog2(NBANK),
  localparam int NL   = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_dev,
  input  logic             cfg_mux,
  input  logic             cfg_bus8,
  input  logic             cfg_wait_en,
  input  logic             cfg_wait_pol,
  input  logic [TW-1:0]    cfg_blead,
  input  logic [TW-1:0]    cfg_rd_aset,
  input  logic [TW-1:0]    cfg_rd_ahld,
  input  logic [TW-1:0]    cfg_rd_dset,
  input  logic [TW-1:0]    cfg_rd_dhld,
  input  logic [TW-1:0]    cfg_rd_turn,
  input  logic             cfg_wr_sep,
  input  logic [TW-1:0]    cfg_wr_aset,
  input  logic [TW-1:0]    cfg_wr_ahld,
  input  logic [TW-1:0]    cfg_wr_dset,
  input  logic [TW-1:0]    cfg_wr_dhld,
  input  logic [TW-1:0]    cfg_wr_turn,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BW-1:0]    req_bank,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [NL-1:0]    req_be,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [NBANK-1:0] mem_cs_n,
  output logic             mem_adv_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [NL-1:0]    mem_bl_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_in,
  input  logic             mem_wait
);
  phase_e        phase;
  logic          start, wait_hold, dset_end, done;
  logic          write_q, sel_write, mux_eff;
  logic [BW-1:0] bank_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, lane_mask;
  logic [NL-1:0] be_q;
  logic [TW-1:0] t_aset, t_ahld, t_dset, t_dhld, t_turn;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  // timing set follows the incoming request while idle, the held one afterwards
  assign sel_write = req_ready ? req_write : write_q;
  assign wait_hold = cfg_wait_en && (mem_wait == cfg_wait_pol);
  assign lane_mask = cfg_bus8 ? DW'(8'hFF) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      bank_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (start) begin
      write_q <= req_write;
      bank_q  <= req_bank;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (dset_end) rdata_q <= mem_dq_in & lane_mask;
  end

  asm_timing_sel #(.TW(TW)) u_tsel (
    .dev      (cfg_dev),
    .mux_req  (cfg_mux),
    .wr_sep   (cfg_wr_sep),
    .is_write (sel_write),
    .rd_aset  (cfg_rd_aset),
    .rd_ahld  (cfg_rd_ahld),
    .rd_dset  (cfg_rd_dset),
    .rd_dhld  (cfg_rd_dhld),
    .rd_turn  (cfg_rd_turn),
    .wr_aset  (cfg_wr_aset),
    .wr_ahld  (cfg_wr_ahld),
    .wr_dset  (cfg_wr_dset),
    .wr_dhld  (cfg_wr_dhld),
    .wr_turn  (cfg_wr_turn),
    .mux_eff  (mux_eff),
    .eff_aset (t_aset),
    .eff_ahld (t_ahld),
    .eff_dset (t_dset),
    .eff_dhld (t_dhld),
    .eff_turn (t_turn)
  );

  asm_phase_ctrl #(.TW(TW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wait_hold (wait_hold),
    .t_blead   (cfg_blead),
    .t_aset    (t_aset),
    .t_ahld    (t_ahld),
    .t_dset    (t_dset),
    .t_dhld    (t_dhld),
    .t_turn    (t_turn),
    .phase     (phase),
    .dset_end  (dset_end),
    .done      (done)
  );

  asm_pin_drv #(.NBANK(NBANK), .AW(AW), .DW(DW)) u_pins (
    .phase     (phase),
    .write_q   (write_q),
    .bank_q    (bank_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .be_q      (be_q),
    .mux_eff   (mux_eff),
    .lane_mask (lane_mask),
    .bus8      (cfg_bus8),
    .cs_n      (mem_cs_n),
    .adv_n     (mem_adv_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .bl_n      (mem_bl_n),
    .addr      (mem_addr),
    .dq_out    (mem_dq_out),
    .dq_oe     (mem_dq_oe)
  );

  assign rsp_valid = done;
  assign rsp_rdata = (phase == PH_DSET) ? (mem_dq_in & lane_mask) : rdata_q;
endmodule

// File: rtl/asm_seq_chk.sv
module asm_seq_chk #(
  parameter int NBANK = 4,
  parameter int DW    = 16,
  localparam int NL   = DW / 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_bus8,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [NBANK-1:0] mem_cs_n,
  input logic             mem_adv_n,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic [NL-1:0]    mem_bl_n,
  input logic [DW-1:0]    mem_dq_out,
  input logic             mem_dq_oe
);
  // R3
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2
  busy_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);

  // R12
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  // R7
  adv_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (mem_dq_oe && mem_oe_n && mem_we_n));

  // R9
  narrow_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bus8 |-> (mem_bl_n[NL-1] && mem_dq_out[DW-1:8] == '0));
endmodule

bind asm_mem_seq asm_seq_chk #(.NBANK(NBANK), .DW(DW)) u_asm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_bus8   (cfg_bus8),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_cs_n   (mem_cs_n),
  .mem_adv_n  (mem_adv_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_bl_n   (mem_bl_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_asm_mem_seq.sv
module test_asm_mem_seq;
  localparam int NBANK = 4, AW = 24, DW = 16, TW = 4, NL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] cfg_dev = 0;
  logic cfg_mux = 0, cfg_bus8 = 0, cfg_wait_en = 0, cfg_wait_pol = 0, cfg_wr_sep = 0;
  logic [TW-1:0] cfg_blead = 0;
  logic [TW-1:0] cfg_rd_aset = 0, cfg_rd_ahld = 0, cfg_rd_dset = 0, cfg_rd_dhld = 0, cfg_rd_turn = 0;
  logic [TW-1:0] cfg_wr_aset = 0, cfg_wr_ahld = 0, cfg_wr_dset = 0, cfg_wr_dhld = 0, cfg_wr_turn = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_bank = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic [NL-1:0] req_be = 0;
  logic req_ready, rsp_valid, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_wait;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [NBANK-1:0] mem_cs_n;
  logic [NL-1:0] mem_bl_n;
  logic [AW-1:0] mem_addr;

  asm_mem_seq i_asm_mem_seq (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // memory model: raises wait for wait_len cycles at the start of each strobe,
  // poisoning the data lines while wait is up
  int  wait_len = 0, wcnt = 0;
  bit  wait_on = 0, in_strobe = 0;
  localparam logic [DW-1:0] POISON = 16'hDEAD;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  assign mem_wait  = wait_on ? cfg_wait_pol : !cfg_wait_pol;
  assign mem_dq_in = wait_on ? POISON : mem_val(mem_addr);

  always @(posedge clk) begin
    #2;
    if (!mem_oe_n || !mem_we_n) begin
      if (!in_strobe) begin
        in_strobe = 1;
        wcnt = wait_len;
      end
      if (wcnt > 0) begin
        wait_on = 1;
        wcnt--;
      end else wait_on = 0;
    end else begin
      in_strobe = 0;
      wait_on = 0;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] bank, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd, input logic [NL-1:0] be, input int w);
    int aset, ahld, dset, dhld, turn, weff, n, k, k_bl, k_cs, advc, g;
    bit mux_ok, use_w;
    logic [DW-1:0] mask, exp_rd;
    string tag;
    use_w  = wr && cfg_wr_sep;
    aset   = use_w ? cfg_wr_aset : cfg_rd_aset;
    ahld   = use_w ? cfg_wr_ahld : cfg_rd_ahld;
    dset   = use_w ? cfg_wr_dset : cfg_rd_dset;
    dhld   = use_w ? cfg_wr_dhld : cfg_rd_dhld;
    turn   = use_w ? cfg_wr_turn : cfg_rd_turn;
    mux_ok = cfg_mux && (cfg_dev == 2'd1 || cfg_dev == 2'd2);
    if (!mux_ok) ahld = 0;
    if (dset == 0) dset = 1;
    weff   = cfg_wait_en ? w : 0;
    n      = cfg_blead + aset + ahld + dset + weff + dhld;
    mask   = cfg_bus8 ? 16'h00FF : 16'hFFFF;
    exp_rd = ((weff == 0 && w >= dset) ? POISON : mem_val(addr)) & mask;
    tag    = use_w ? "R8" : (w > 0 ? (cfg_wait_en ? "R10" : "R11") : "R3");

    wait_len = w;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bank = bank; req_addr = addr;
    req_wdata = wd; req_be = be;
    @(posedge clk);
    #1 req_valid = 0;
    k = 0; k_bl = -1; k_cs = -1; advc = 0;
    while (1) begin
      @(negedge clk);
      k++;
      if (k == 1) check(req_ready == 1'b0, "R2", req_ready, 0);
      if (k_bl < 0 && mem_bl_n != '1) k_bl = k;
      if (k_cs < 0 && mem_cs_n != '1) begin
        k_cs = k;
        check(mem_cs_n == ~(4'b1 << bank), "R6", mem_cs_n, ~(4'b1 << bank));
        if (cfg_bus8) check(mem_bl_n[1] == 1'b1, "R9", mem_bl_n, 2'b10);
      end
      if (!mem_adv_n) begin
        advc++;
        check(mem_dq_oe && mem_dq_out == (addr[15:0] & mask), "R7", mem_dq_out, addr[15:0] & mask);
      end
      if (!mem_we_n)
        check(mem_dq_oe && mem_dq_out == (wd & mask), "R12", mem_dq_out, wd & mask);
      if (rsp_valid || k > 400) break;
    end
    check(k == n, tag, k, n);
    check(advc == (mux_ok ? aset + ahld : 0), "R7", advc, mux_ok ? aset + ahld : 0);
    if (be[0]) check(k_cs - k_bl == int'(cfg_blead), "R5", k_cs - k_bl, cfg_blead);
    if (!wr) check(rsp_rdata == exp_rd, w > 0 ? (cfg_wait_en ? "R10" : "R11") : "R12",
                   rsp_rdata, exp_rd);
    g = 0;
    do begin
      @(negedge clk);
      g++;
      if (g == 1) check(rsp_valid == 1'b0, "R3", rsp_valid, 0);
    end while (!req_ready && g < 100);
    check(g == turn + 1, "R4", g, turn + 1);
  endtask

  task automatic set_rd(input int a, input int ah, input int d, input int dh, input int t);
    cfg_rd_aset = TW'(a); cfg_rd_ahld = TW'(ah); cfg_rd_dset = TW'(d);
    cfg_rd_dhld = TW'(dh); cfg_rd_turn = TW'(t);
  endtask

  task automatic set_wr(input int a, input int ah, input int d, input int dh, input int t);
    cfg_wr_aset = TW'(a); cfg_wr_ahld = TW'(ah); cfg_wr_dset = TW'(d);
    cfg_wr_dhld = TW'(dh); cfg_wr_turn = TW'(t);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", req_ready, 1);
    check(rsp_valid == 1'b0, "R1", rsp_valid, 0);
    check(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && mem_adv_n && !mem_dq_oe, "R1",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe}, 8'hFE);

    // plain read and write, shared timing set (R3, R12)
    cfg_blead = 2; set_rd(3, 5, 4, 2, 3);
    access(0, 2'd1, 24'h001234, 16'h0, 2'b11, 0);
    access(1, 2'd3, 24'h00ABCD, 16'hBEEF, 2'b11, 0);
    // all zero phases: data setup forced to one cycle (R3, R5)
    cfg_blead = 0; set_rd(0, 0, 0, 0, 0);
    access(0, 2'd0, 24'h000042, 16'h0, 2'b01, 0);
    // separate write timing set (R8)
    cfg_wr_sep = 1; set_rd(1, 0, 2, 1, 1); set_wr(4, 0, 6, 3, 5);
    access(1, 2'd2, 24'h000777, 16'h1357, 2'b11, 0);
    access(0, 2'd2, 24'h000778, 16'h0, 2'b11, 0);
    cfg_wr_sep = 0;
    // multiplexed on NOR and on SRAM (R7)
    cfg_mux = 1; cfg_dev = 2'd2; set_rd(2, 3, 2, 1, 2);
    access(0, 2'd1, 24'h00C0DE, 16'h0, 2'b11, 0);
    cfg_dev = 2'd0;
    access(0, 2'd1, 24'h00C0DF, 16'h0, 2'b11, 0);
    cfg_mux = 0;
    // narrow bus (R9)
    cfg_bus8 = 1; cfg_blead = 1;
    access(1, 2'd0, 24'h000101, 16'hFACE, 2'b11, 0);
    access(0, 2'd0, 24'h000102, 16'h0, 2'b11, 0);
    cfg_bus8 = 0;
    // wait coinciding with a one-cycle data setup, both polarities (R10)
    cfg_wait_en = 1; cfg_wait_pol = 0; set_rd(1, 0, 1, 0, 1);
    access(0, 2'd3, 24'h000500, 16'h0, 2'b11, 3);
    cfg_wait_pol = 1;
    access(0, 2'd3, 24'h000501, 16'h0, 2'b11, 2);
    // wait ignored when disabled: length unchanged, poisoned data captured (R11)
    cfg_wait_en = 0;
    access(0, 2'd3, 24'h000502, 16'h0, 2'b11, 4);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      cfg_dev = 2'($urandom_range(0, 3)); cfg_mux = 1'($urandom_range(0, 1));
      cfg_bus8 = 1'($urandom_range(0, 1)); cfg_wait_en = 1'($urandom_range(0, 1));
      cfg_wait_pol = 1'($urandom_range(0, 1)); cfg_wr_sep = 1'($urandom_range(0, 1));
      cfg_blead = TW'($urandom_range(0, 15));
      set_rd($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
             $urandom_range(0, 15), $urandom_range(0, 15));
      set_wr($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
             $urandom_range(0, 15), $urandom_range(0, 15));
      access(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), AW'($urandom),
             DW'($urandom), {1'($urandom_range(0, 1)), 1'b1}, $urandom_range(0, 4));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule